// File: doc/BRIEF.md
# MESI Snoop Controller with Wired-OR Shared Line

This block keeps one private, direct-mapped cache coherent with its peers on an atomic snooping bus. It uses four line states: Modified, Exclusive, Shared and Invalid. The processor side presents reads and writes and holds each request until `cpu_done_o` pulses. Every hit in a state that permits the access completes in the cycle it is seen. A miss, or a write to a Shared line, raises a bus request carrying a read, a read-for-ownership, or a write-back flush. The controller then installs the returned line in the cycle after its grant.

Each peer cache reports through a wired-OR line whether it holds the block. A read miss samples that line one cycle after its address phase and installs the block Exclusive when nobody answered, or Shared otherwise. A later write to an Exclusive line becomes Modified with no bus traffic.

On the snoop side, a transaction seen in one cycle is looked up in the next. In that cycle the controller raises its shared output, flushes its data when it is the supplier, and moves the line to its new state. Among several Shared holders, a fixed-priority chain ordered by cache position lets only the first holder supply.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: `shared_o` is high in the cycle after a snooped read (command 0) whose address hits a valid line, and low for every other snoop and for misses.
- R2: A processor read that misses raises one bus read (command 0). In the cycle after its grant, the line is installed with `fill_data_i`, as Shared if `shared_i` is high in that cycle and as Exclusive if it is low.
- R3: A processor write to an Invalid or Shared line raises one read-for-ownership (command 1) at the request address and leaves the line Modified, holding the written data.
- R4: Reads that hit Shared, Exclusive or Modified lines, and writes that hit Exclusive or Modified lines, complete in the cycle they are seen with no bus request; a write hit to Exclusive leaves the line Modified.
- R5: A snooped read hitting a Modified or Exclusive line flushes the line data in the cycle after the address phase, and the line becomes Shared.
- R6: A snooped read-for-ownership invalidates a hit line; Modified and Exclusive lines flush their data, while Shared lines do not.
- R7: A Shared line hit by a snooped read flushes only when `sup_chain_i` is low; `sup_chain_o` is high when `sup_chain_i` is high or this cache holds the block Shared.
- R8: A miss whose victim line is Modified first issues a flush (command 2) carrying the victim's address and data, then the miss request; Exclusive and Shared victims are dropped without bus traffic.
- R9: After reset, every line is Invalid and no request, completion, shared or flush output is active.
- R10: A snooped flush (command 2) changes no line and drives neither `shared_o` nor `flush_o`.
- R11: While a snoop is in its address or response cycle, the controller neither completes a processor request nor raises a bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Processor request held until done |
| cpu_write_i | input | 1 | Request is a write |
| cpu_addr_i | input | ADDR_W | Request address; low IDX_W bits select the line |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_done_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid with done |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_gnt_i | input | 1 | Grant; this cycle is the address phase |
| bus_cmd_o | output | 2 | 0 read, 1 read-for-ownership, 2 flush, 3 none |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_data_o | output | DATA_W | Write-back data for a flush |
| shared_i | input | 1 | Wired-OR shared line, sampled in the fill cycle |
| fill_data_i | input | DATA_W | Line data returned in the fill cycle |
| snp_valid_i | input | 1 | Peer transaction address phase |
| snp_cmd_i | input | 2 | Peer command, same encoding |
| snp_addr_i | input | ADDR_W | Peer address |
| shared_o | output | 1 | This cache holds the snooped block |
| flush_o | output | 1 | This cache supplies the data |
| flush_data_o | output | DATA_W | Supplied line data |
| sup_chain_i | input | 1 | A higher-priority cache already supplies |
| sup_chain_o | output | 1 | Supply claim passed to the next cache |

## Verification
A wrong line state surfaces at the ports either at the next snoop to that line or at the next processor access to it. A line left Exclusive instead of Shared flushes on a later read-for-ownership where a Shared line would stay silent. A line wrongly left valid answers `shared_o` one cycle after a peer read, or completes a read with stale data and no bus request. A lost Modified state appears at eviction as a missing flush before the miss. The stimulus therefore follows each state change with a snoop or an access that makes the state visible within two cycles.

// File: rtl/mesi_snoop_pkg.sv
package mesi_snoop_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_e;
  typedef enum logic [1:0] {CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_FLUSH = 2'd2, CMD_NONE = 2'd3} bus_cmd_e;
endpackage

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_snoop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2,
  parameter bit C2C_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  line_st_e          line_st_i,
  input  logic [ADDR_W-IDX_W-1:0] line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              sup_chain_i,
  output logic [IDX_W-1:0]  look_idx_o,
  output logic              busy_o,
  output logic              shared_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] flush_data_o,
  output logic              sup_chain_o,
  output logic              upd_en_o,
  output line_st_e          upd_st_o
);
  logic              v_q;
  bus_cmd_e          cmd_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      cmd_q  <= CMD_NONE;
      addr_q <= '0;
    end else begin
      v_q <= snp_valid_i;
      if (snp_valid_i) begin
        cmd_q  <= bus_cmd_e'(snp_cmd_i);
        addr_q <= snp_addr_i;
      end
    end
  end

  logic hit, is_rd, is_rdx, s_cand, own_flush, xfer_flush;
  assign look_idx_o = addr_q[IDX_W-1:0];
  assign hit    = v_q && (line_st_i != ST_I) && (line_tag_i == addr_q[ADDR_W-1:IDX_W]);
  assign is_rd  = cmd_q == CMD_RD;
  assign is_rdx = cmd_q == CMD_RDX;
  assign s_cand = hit && is_rd && (line_st_i == ST_S);

  // dirty owner must always supply
  assign own_flush = hit && (is_rd || is_rdx) && (line_st_i == ST_M);

  generate
    if (C2C_EN) begin : g_c2c
      assign xfer_flush = (hit && (is_rd || is_rdx) && (line_st_i == ST_E)) ||
                          (s_cand && !sup_chain_i);
    end else begin : g_no_c2c
      assign xfer_flush = 1'b0;
    end
  endgenerate

  assign busy_o       = snp_valid_i || v_q;
  assign shared_o     = hit && is_rd;
  assign flush_o      = own_flush || xfer_flush;
  assign flush_data_o = line_data_i;
  assign sup_chain_o  = sup_chain_i || s_cand;
  assign upd_en_o     = hit && (is_rd || is_rdx);
  assign upd_st_o     = is_rdx ? ST_I : ST_S;

  p_shared_rd_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_o |-> ($past(snp_valid_i) && $past(snp_cmd_i) == CMD_RD));
  p_flush_not_on_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> ($past(snp_valid_i) && $past(snp_cmd_i) != CMD_FLUSH));
  p_chain_yield_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_chain_i |-> (sup_chain_o && !(flush_o && line_st_i == ST_S)));
  p_rdx_invalidates_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_o && $past(snp_cmd_i) == CMD_RDX) |-> (upd_st_o == ST_I && !shared_o));
endmodule

// File: rtl/mesi_req_ctrl.sv
module mesi_req_ctrl
  import mesi_snoop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic              cpu_write_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              snoop_busy_i,
  input  line_st_e          line_st_i,
  input  logic [ADDR_W-IDX_W-1:0] line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              shared_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              wr_en_o,
  output line_st_e          wr_st_o,
  output logic [ADDR_W-IDX_W-1:0] wr_tag_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_data_en_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic fill_q, rdx_q;
  logic [TAG_W-1:0] cpu_tag;
  logic hit, go, wr_ok, done, need_bus, victim_wb;
  bus_cmd_e cmd;

  assign cpu_tag   = cpu_addr_i[ADDR_W-1:IDX_W];
  assign hit       = (line_st_i != ST_I) && (line_tag_i == cpu_tag);
  assign go        = cpu_valid_i && !snoop_busy_i && !fill_q;
  assign wr_ok     = hit && ((line_st_i == ST_E) || (line_st_i == ST_M));
  assign done      = go && hit && (!cpu_write_i || wr_ok);
  assign need_bus  = go && !done;
  assign victim_wb = !hit && (line_st_i == ST_M);

  always_comb begin
    if (!need_bus)        cmd = CMD_NONE;
    else if (victim_wb)   cmd = CMD_FLUSH;
    else if (cpu_write_i) cmd = CMD_RDX;
    else                  cmd = CMD_RD;
  end

  assign cpu_done_o  = done;
  assign cpu_rdata_o = line_data_i;
  assign bus_req_o   = need_bus;
  assign bus_cmd_o   = cmd;
  assign bus_addr_o  = victim_wb ? {line_tag_i, cpu_addr_i[IDX_W-1:0]} : cpu_addr_i;
  assign bus_data_o  = line_data_i;

  always_comb begin
    wr_en_o      = 1'b0;
    wr_st_o      = line_st_i;
    wr_tag_o     = line_tag_i;
    wr_data_o    = cpu_wdata_i;
    wr_data_en_o = 1'b0;
    if (fill_q) begin
      wr_en_o      = 1'b1;
      wr_st_o      = rdx_q ? ST_M : (shared_i ? ST_S : ST_E);
      wr_tag_o     = cpu_tag;
      wr_data_o    = fill_data_i;
      wr_data_en_o = 1'b1;
    end else if (done && cpu_write_i) begin
      wr_en_o      = 1'b1;
      wr_st_o      = ST_M;
      wr_data_en_o = 1'b1;
    end else if (need_bus && bus_gnt_i && victim_wb) begin
      wr_en_o = 1'b1;
      wr_st_o = ST_I;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= 1'b0;
      rdx_q  <= 1'b0;
    end else begin
      fill_q <= need_bus && bus_gnt_i && !victim_wb;
      rdx_q  <= cpu_write_i;
    end
  end

  p_fill_after_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q |-> ($past(bus_gnt_i) && $past(bus_req_o) && $past(bus_cmd_o) != CMD_FLUSH));
  p_quiet_in_snoop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_busy_i |-> (!bus_req_o && !cpu_done_o));
  p_wb_before_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_cmd_o == CMD_FLUSH) |=> !fill_q);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_snoop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 4,
  parameter bit C2C_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic              cpu_write_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              shared_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              shared_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] flush_data_o,
  input  logic              sup_chain_i,
  output logic              sup_chain_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic              snp_busy, snp_upd, req_we, req_den;
  line_st_e          snp_st, req_st;
  logic [TAG_W-1:0]  req_tag;
  logic [DATA_W-1:0] req_data;

  assign cpu_idx = cpu_addr_i[IDX_W-1:0];

  mesi_snoop_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .C2C_EN(C2C_EN)) u_snp (
    .clk_i, .rst_ni, .snp_valid_i, .snp_cmd_i, .snp_addr_i,
    .line_st_i(st_q[snp_idx]), .line_tag_i(tag_q[snp_idx]), .line_data_i(data_q[snp_idx]),
    .sup_chain_i, .look_idx_o(snp_idx), .busy_o(snp_busy), .shared_o, .flush_o,
    .flush_data_o, .sup_chain_o, .upd_en_o(snp_upd), .upd_st_o(snp_st)
  );

  mesi_req_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_req (
    .clk_i, .rst_ni, .cpu_valid_i, .cpu_write_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_done_o, .cpu_rdata_o, .snoop_busy_i(snp_busy),
    .line_st_i(st_q[cpu_idx]), .line_tag_i(tag_q[cpu_idx]), .line_data_i(data_q[cpu_idx]),
    .bus_req_o, .bus_gnt_i, .bus_cmd_o, .bus_addr_o, .bus_data_o, .shared_i, .fill_data_i,
    .wr_en_o(req_we), .wr_st_o(req_st), .wr_tag_o(req_tag), .wr_data_o(req_data),
    .wr_data_en_o(req_den)
  );

  // snoop and processor updates never overlap on an atomic bus; snoop wins if they do
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (snp_upd) begin
      st_q[snp_idx] <= snp_st;
    end else if (req_we) begin
      st_q[cpu_idx]  <= req_st;
      tag_q[cpu_idx] <= req_tag;
      if (req_den) data_q[cpu_idx] <= req_data;
    end
  end

  p_done_excl_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_done_o && bus_req_o));
  p_flush_needs_holder_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (st_q[snp_idx] != ST_I));
  p_silent_upgrade_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_done_o && cpu_write_i && st_q[cpu_idx] == ST_E) |=> (st_q[$past(cpu_idx)] == ST_M));
endmodule

// File: tb/sim_mesi_snoop_ctrl.sv
module sim_mesi_snoop_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cpu_valid = 0, cpu_write = 0, cpu_done, bus_req, bus_gnt = 0, shr_in = 0;
  logic snp_valid = 0, shared_o, flush_o, chain_in = 0, chain_out;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata, bus_addr, bus_data, fill = 0;
  logic [7:0] snp_addr = 0, flush_data;
  logic [1:0] bus_cmd, snp_cmd = 0;

  mesi_snoop_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_valid_i(cpu_valid), .cpu_write_i(cpu_write),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_data_o(bus_data), .shared_i(shr_in), .fill_data_i(fill), .snp_valid_i(snp_valid),
    .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr), .shared_o(shared_o), .flush_o(flush_o),
    .flush_data_o(flush_data), .sup_chain_i(chain_in), .sup_chain_o(chain_out)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 200000; k++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  // cmd: 0 read, 1 read-for-ownership, 2 flush
  task automatic cpu_op(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        input logic shr, input logic [7:0] f, output int nbus,
                        output logic [1:0] c0, output logic [7:0] a0, output logic [7:0] d0,
                        output logic [7:0] rd, output logic ok);
    logic [1:0] cmd;
    nbus = 0; c0 = 2'd3; a0 = 0; d0 = 0; rd = 0; ok = 0;
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_addr = a; cpu_wdata = d;
    for (int k = 0; k < 20 && !ok; k++) begin
      #1;
      if (cpu_done) begin
        rd = cpu_rdata; ok = 1;
        @(posedge clk);
      end else if (bus_req) begin
        cmd = bus_cmd;
        if (nbus == 0) begin c0 = bus_cmd; a0 = bus_addr; d0 = bus_data; end
        nbus++;
        bus_gnt = 1;
        @(posedge clk);
        @(negedge clk);
        bus_gnt = 0;
        if (cmd != 2'd2) begin
          shr_in = shr; fill = f;
          @(posedge clk);
          @(negedge clk);
          shr_in = 0;
        end
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    cpu_valid = 0; cpu_write = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a,
                       output logic sh, output logic fl, output logic [7:0] fd, output logic ch);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(posedge clk);
    @(negedge clk);
    snp_valid = 0;
    #1;
    sh = shared_o; fl = flush_o; fd = flush_data; ch = chain_out;
    @(posedge clk);
  endtask

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] op;    // 0 read, 1 write, 2 snoop
    logic [1:0] cmd;
    logic [7:0] addr;
    logic [7:0] dat;   // write data, or expected write-back data
    logic       shr;
    logic [7:0] fill;
    logic [1:0] nbus;
    logic [1:0] c0;
    logic [7:0] a0;
    logic [7:0] val;   // read data or flush data
    logic       esh;
    logic       efl;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{4'd2,  2'd0, 2'd0, 8'h10, 8'h00, 1'b0, 8'hA1, 2'd1, 2'd0, 8'h10, 8'hA1, 1'b0, 1'b0}, // R2 R9 miss->E
    '{4'd4,  2'd1, 2'd0, 8'h10, 8'h55, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h00, 1'b0, 1'b0}, // R4 E->M silent
    '{4'd4,  2'd0, 2'd0, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h55, 1'b0, 1'b0}, // R4
    '{4'd5,  2'd2, 2'd0, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h55, 1'b1, 1'b1}, // R5 R1 M->S
    '{4'd5,  2'd0, 2'd0, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h55, 1'b0, 1'b0}, // R5 S hit
    '{4'd7,  2'd2, 2'd0, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h55, 1'b1, 1'b1}, // R7 S supplier
    '{4'd3,  2'd1, 2'd0, 8'h10, 8'h66, 1'b0, 8'h55, 2'd1, 2'd1, 8'h10, 8'h00, 1'b0, 1'b0}, // R3 S write
    '{4'd3,  2'd0, 2'd0, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h66, 1'b0, 1'b0}, // R3
    '{4'd6,  2'd2, 2'd1, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h66, 1'b0, 1'b1}, // R6 M inv
    '{4'd2,  2'd0, 2'd0, 8'h10, 8'h00, 1'b1, 8'h77, 2'd1, 2'd0, 8'h10, 8'h77, 1'b0, 1'b0}, // R2 miss->S
    '{4'd6,  2'd2, 2'd1, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h00, 1'b0, 1'b0}, // R6 S inv silent
    '{4'd6,  2'd0, 2'd0, 8'h10, 8'h00, 1'b0, 8'h88, 2'd1, 2'd0, 8'h10, 8'h88, 1'b0, 1'b0}, // R6 now I
    '{4'd5,  2'd2, 2'd0, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h88, 1'b1, 1'b1}, // R5 E->S
    '{4'd1,  2'd2, 2'd0, 8'h11, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h00, 1'b0, 1'b0}, // R1 miss
    '{4'd8,  2'd1, 2'd0, 8'h14, 8'h99, 1'b0, 8'h00, 2'd1, 2'd1, 8'h14, 8'h00, 1'b0, 1'b0}, // R8 S victim
    '{4'd8,  2'd0, 2'd0, 8'h18, 8'h99, 1'b0, 8'h42, 2'd2, 2'd2, 8'h14, 8'h42, 1'b0, 1'b0}, // R8 M victim
    '{4'd1,  2'd2, 2'd0, 8'h14, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h00, 1'b0, 1'b0}, // R1 stale tag
    '{4'd6,  2'd2, 2'd1, 8'h18, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h42, 1'b0, 1'b1}, // R6 E inv
    '{4'd6,  2'd0, 2'd0, 8'h18, 8'h00, 1'b1, 8'h43, 2'd1, 2'd0, 8'h18, 8'h43, 1'b0, 1'b0}, // R6 now I
    '{4'd10, 2'd2, 2'd2, 8'h18, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h00, 1'b0, 1'b0}, // R10
    '{4'd10, 2'd0, 2'd0, 8'h18, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h43, 1'b0, 1'b0}, // R10 still S
    '{4'd3,  2'd1, 2'd0, 8'h18, 8'h5A, 1'b0, 8'h43, 2'd1, 2'd1, 8'h18, 8'h00, 1'b0, 1'b0}, // R3
    '{4'd5,  2'd2, 2'd0, 8'h18, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h5A, 1'b1, 1'b1}, // R5 M->S
    '{4'd4,  2'd0, 2'd0, 8'h18, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h5A, 1'b0, 1'b0}, // R4 S read
    '{4'd1,  2'd2, 2'd1, 8'h12, 8'h00, 1'b0, 8'h00, 2'd0, 2'd3, 8'h00, 8'h00, 1'b0, 1'b0}  // R1 rdx miss
  };

  initial begin
    int nb;
    logic [1:0] c0;
    logic [7:0] a0, d0, rd, fd;
    logic ok, sh, fl, ch;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: idle outputs in reset and just after
    chk(9, "done in reset", cpu_done, 0);
    chk(9, "bus_req in reset", bus_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk(9, "shared after reset", shared_o, 0);
    chk(9, "flush after reset", flush_o, 0);
    chk(9, "chain after reset", chain_out, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      if (v.op == 2'd2) begin
        snoop(v.cmd, v.addr, sh, fl, fd, ch);
        chk(v.req, $sformatf("row %0d shared", i), sh, v.esh);
        chk(v.req, $sformatf("row %0d flush", i), fl, v.efl);
        if (v.efl) chk(v.req, $sformatf("row %0d flush data", i), fd, v.val);
      end else begin
        cpu_op(v.op[0], v.addr, v.dat, v.shr, v.fill, nb, c0, a0, d0, rd, ok);
        chk(v.req, $sformatf("row %0d done", i), ok, 1);
        chk(v.req, $sformatf("row %0d bus count", i), nb, v.nbus);
        if (v.nbus != 0) begin
          chk(v.req, $sformatf("row %0d first cmd", i), c0, v.c0);
          chk(v.req, $sformatf("row %0d first addr", i), a0, v.a0);
          if (v.c0 == 2'd2) chk(v.req, $sformatf("row %0d writeback data", i), d0, v.dat);
        end
        if (v.op == 2'd0) chk(v.req, $sformatf("row %0d read data", i), rd, v.val);
      end
    end

    // R7: line 0x18 is Shared; a higher-priority holder already supplies
    chain_in = 1;
    snoop(2'd0, 8'h18, sh, fl, fd, ch);
    chk(7, "chain shared", sh, 1);
    chk(7, "chain yields flush", fl, 0);
    chk(7, "chain passed on", ch, 1);
    chain_in = 0;

    // R11: hit request held off while a snoop is in flight
    @(negedge clk);
    snp_valid = 1; snp_cmd = 2'd0; snp_addr = 8'h11;
    cpu_valid = 1; cpu_write = 0; cpu_addr = 8'h18;
    #1;
    chk(11, "done in addr phase", cpu_done, 0);
    chk(11, "req in addr phase", bus_req, 0);
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk(11, "done in resp phase", cpu_done, 0);
    chk(11, "req in resp phase", bus_req, 0);
    @(negedge clk);
    #1;
    chk(11, "done after snoop", cpu_done, 1);
    chk(11, "data after snoop", cpu_rdata, 8'h5A);
    @(negedge clk);
    cpu_valid = 0;

    repeat (2) @(negedge clk);
    summary();
  end
endmodule